// File: doc/BRIEF.md
# Two-wire register slave for clock-control bytes

This block is a slave on a two-wire serial management bus. It answers to the 7-bit device address 69h, which is the 8-bit value D2h for a write and D3h for a read. Through it, a bus master reads and writes eight 8-bit control bytes, and those bytes drive the clock-generation logic around it. The logic that uses the bytes sees them on one flat output bus. The serial line inputs must already be synchronised to `clk`, and the clock must run several times faster than the bus clock. The block pulls the data line low through an open-drain enable.

The command byte chooses the kind of access:
- If command bit 7 is 1, the access is indexed. Bits 6:0 give the offset of a single byte to read or write.
- If command bit 7 is 0, the access is a block access. It starts at offset 0 and the offset rises by one per data byte.
- A block write carries a byte count after the command. That count is accepted and then ignored.
- A block read first returns a count of 8 and then the data bytes.

Some fields are read-only:
- Byte 6 bits 2:0 show the strap levels latched elsewhere.
- Byte 7 holds a fixed identity value.
- Offsets above 7 read as zero and absorb writes.

Top module: `smb_ctrl_regs`

## Requirements
- R1: A first byte whose upper seven bits equal 69h is acknowledged. Any other address gets no acknowledge, and the slave then acknowledges no further byte and writes nothing until the next start condition.
- R2: An indexed write (command bit 7 = 1, offset in bits 6:0, then one data byte) stores the data into the register at that offset. The slave acknowledges the address, the command and the data.
- R3: An indexed read (command, repeated start, D3h) returns the byte at the commanded offset, most significant bit first. A master NACK after that byte ends the read.
- R4: A block write (command 00h, a count byte, then data) stores the data bytes at offsets 0, 1, 2 and onward in order. A stop after any complete byte leaves the higher offsets unchanged.
- R5: A block read (command 00h, repeated start, D3h) returns the value 8 first and then bytes 0, 1, 2 and onward while the master acknowledges.
- R6: After reset the bytes at offsets 0 to 7 are FFh, FEh, FFh, 00h, 00h, 00h, 18h with the straps in bits 2:0, and 08h.
- R7: Three kinds of field are read-only:
  - Byte 7 always reads 08h.
  - Byte 6 bits 2:0 always equal `strapIn`, and only bits 7:3 of byte 6 take written data.
  - Offsets 8 to 127 read 00h, and writes to them change nothing.
- R8: A stop condition at any point returns the slave to idle. A data byte cut short by a stop is not written.
- R9: `regOut` bits 8k+7 to 8k show byte k at all times. This includes the strap bits.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the bus lines |
| rstN | input | 1 | Active-low asynchronous reset to defaults |
| sclIn | input | 1 | Synchronised bus clock line |
| sdaIn | input | 1 | Synchronised bus data line (wired level) |
| strapIn | input | 3 | Latched strap levels shown in byte 6 bits 2:0 |
| sdaOe | output | 1 | 1 pulls the data line low |
| regOut | output | 64 | All eight bytes, byte k at bits 8k+7:8k |

## Verification
A wrong bit counter or a wrong phase state in the bus controller shows up in the same bus bit in which it occurs. It appears as a missing or extra acknowledge, or as a shifted read byte that differs from the model. A wrong offset pointer or a wrong write mask changes `regOut` within a few clocks after the data byte. The model compares `regOut` on every clock between transactions, so such a fault is caught before the next transaction starts. A stuck read-only field is caught both through a readback over the bus and directly on `regOut`.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam int IDX_W = 7;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [7:0]       wrData;
    logic [IDX_W-1:0] rdIdx;
  } regStrobeT;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} busStateT;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_COUNT, K_DATA} rxKindT;

  function automatic logic [7:0] resetValue(input int k);
    case (k)
      0, 2:    resetValue = 8'hFF;
      1:       resetValue = 8'hFE;
      6:       resetValue = 8'h18;
      7:       resetValue = 8'h08;
      default: resetValue = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] writeMask(input int k, input int strapW);
    if (k < 6)       writeMask = 8'hFF;
    else if (k == 6) writeMask = 8'hFF << strapW;
    else             writeMask = 8'h00;
  endfunction

endpackage

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR       = 7'h69,
  parameter int         NUM_BYTES      = 8,
  parameter bit         BLOCK_COUNT_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output regStrobeT  strobe,
  output logic       sdaOe
);

  localparam logic [7:0] COUNT_BYTE = 8'(NUM_BYTES);

  busStateT         state;
  rxKindT           rxKind;
  logic             sclQ, sdaQ;
  logic [2:0]       bitCnt;
  logic [7:0]       shiftR;
  logic             byteFull, ackToTx, sendCount, mackOk;
  logic [IDX_W-1:0] ptr, wrIdxQ;
  logic [7:0]       wrDataQ;
  logic             wrEnQ;

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclIn & ~sclQ;
  assign sclFall  = ~sclIn & sclQ;
  assign startDet = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopDet  = sclIn & sclQ & ~sdaQ & sdaIn;

  always_comb begin
    strobe.wrEn   = wrEnQ;
    strobe.wrIdx  = wrIdxQ;
    strobe.wrData = wrDataQ;
    strobe.rdIdx  = ptr;
  end

  assign sdaOe = (state == S_ACK) | ((state == S_TX) & ~shiftR[7]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      rxKind    <= K_ADDR;
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      bitCnt    <= '0;
      shiftR    <= '0;
      byteFull  <= 1'b0;
      ackToTx   <= 1'b0;
      sendCount <= 1'b0;
      mackOk    <= 1'b0;
      ptr       <= '0;
      wrEnQ     <= 1'b0;
      wrIdxQ    <= '0;
      wrDataQ   <= '0;
    end else begin
      sclQ  <= sclIn;
      sdaQ  <= sdaIn;
      wrEnQ <= 1'b0;
      if (startDet) begin
        state    <= S_RX;
        rxKind   <= K_ADDR;
        bitCnt   <= '0;
        byteFull <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise) begin
              shiftR <= {shiftR[6:0], sdaIn};
              bitCnt <= 3'(bitCnt + 1);
              if (bitCnt == 3'd7) byteFull <= 1'b1;
            end else if (sclFall && byteFull) begin
              byteFull <= 1'b0;
              state    <= S_ACK;
              ackToTx  <= 1'b0;
              case (rxKind)
                K_ADDR: begin
                  if (shiftR[7:1] != DEV_ADDR) state <= S_IDLE;
                  else if (shiftR[0])          ackToTx <= 1'b1;
                  else                         rxKind <= K_CMD;
                end
                K_CMD: begin
                  ptr       <= shiftR[7] ? shiftR[6:0] : '0;
                  sendCount <= ~shiftR[7];
                  rxKind    <= (!shiftR[7] && BLOCK_COUNT_EN) ? K_COUNT : K_DATA;
                end
                K_COUNT: rxKind <= K_DATA;
                default: begin
                  wrEnQ   <= 1'b1;
                  wrIdxQ  <= ptr;
                  wrDataQ <= shiftR;
                  ptr     <= IDX_W'(ptr + 1);
                end
              endcase
            end
          end
          S_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (ackToTx) begin
                state <= S_TX;
                if (sendCount) begin
                  shiftR    <= COUNT_BYTE;
                  sendCount <= 1'b0;
                end else begin
                  shiftR <= rdData;
                  ptr    <= IDX_W'(ptr + 1);
                end
              end else begin
                state <= S_RX;
              end
            end
          end
          S_TX: begin
            if (sclFall) begin
              bitCnt <= 3'(bitCnt + 1);
              if (bitCnt == 3'd7) begin
                state  <= S_MACK;
                mackOk <= 1'b0;
              end else begin
                shiftR <= {shiftR[6:0], 1'b1};
              end
            end
          end
          S_MACK: begin
            if (sclRise) begin
              if (sdaIn) state <= S_IDLE;
              else       mackOk <= 1'b1;
            end else if (sclFall && mackOk) begin
              state  <= S_TX;
              bitCnt <= '0;
              if (sendCount) begin
                shiftR    <= COUNT_BYTE;
                sendCount <= 1'b0;
              end else begin
                shiftR <= rdData;
                ptr    <= IDX_W'(ptr + 1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: drive changes only while the bus clock is low
  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sclQ && sclIn && $past(sclIn)) |-> $stable(sdaOe));

  // R8: a stop always leaves the controller idle
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == S_IDLE));

  // R1: a new start always restarts address reception
  a_r1_start_addr: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == S_RX && rxKind == K_ADDR && bitCnt == 3'd0));

  // R2: one write strobe per received data byte
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrEnQ |=> !wrEnQ);

endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int STRAP_W   = 3,
  parameter int STRAP_IDX = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobeT              strobe,
  input  logic [STRAP_W-1:0]     strapIn,
  output logic [7:0]             rdData,
  output logic [NUM_BYTES*8-1:0] regOut
);

  localparam int SEL_W = $clog2(NUM_BYTES);

  logic [NUM_BYTES-1:0][7:0] regQ;
  logic [NUM_BYTES-1:0][7:0] view;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    localparam logic [7:0] MASK = writeMask(k, STRAP_W);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= resetValue(k);
      else if (strobe.wrEn && strobe.wrIdx == IDX_W'(k))
        q <= (q & ~MASK) | (strobe.wrData & MASK);
    end
    assign regQ[k] = q;
    if (k == STRAP_IDX) begin : g_strap
      assign view[k] = {q[7:STRAP_W], strapIn};
    end else begin : g_plain
      assign view[k] = q;
    end
    assign regOut[8*k +: 8] = view[k];
  end

  assign rdData = (strobe.rdIdx < IDX_W'(NUM_BYTES)) ? view[strobe.rdIdx[SEL_W-1:0]] : 8'h00;

  // R7: writes outside the writable range change no stored bit
  a_r7_ro_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrIdx >= IDX_W'(NUM_BYTES - 1)) |=> $stable(regQ));

  // R2: a write to offset 0 lands in full
  a_r2_write_byte0: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrIdx == '0) |=> (regOut[7:0] == $past(strobe.wrData)));

endmodule

// File: rtl/smb_ctrl_regs.sv
module smb_ctrl_regs
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR       = 7'h69,
  parameter int         NUM_BYTES      = 8,
  parameter int         STRAP_W        = 3,
  parameter bit         BLOCK_COUNT_EN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [STRAP_W-1:0]     strapIn,
  output logic                   sdaOe,
  output logic [NUM_BYTES*8-1:0] regOut
);

  regStrobeT  strobe;
  logic [7:0] rdData;

  smb_ctrl #(
    .DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES), .BLOCK_COUNT_EN(BLOCK_COUNT_EN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .strobe(strobe), .sdaOe(sdaOe)
  );

  smb_regs #(
    .NUM_BYTES(NUM_BYTES), .STRAP_W(STRAP_W), .STRAP_IDX(6)
  ) i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .strapIn(strapIn),
    .rdData(rdData), .regOut(regOut)
  );

endmodule

// File: tb/test_smb_ctrl_regs.sv
module test_smb_ctrl_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mScl = 1'b1;
  logic        mSda = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic        sdaOe;
  logic [63:0] regOut;
  logic        sdaBus;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit busy = 1'b1;
  logic [7:0] model [8];

  assign sdaBus = mSda & ~sdaOe;

  always #5 clk = ~clk;

  smb_ctrl_regs i_smb_ctrl_regs (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .strapIn(strap), .sdaOe(sdaOe), .regOut(regOut)
  );

  function automatic logic [7:0] expByte(input int off);
    if (off > 7)       return 8'h00;
    else if (off == 6) return {model[6][7:3], strap};
    else               return model[off];
  endfunction

  function automatic logic [63:0] expFlat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[8*k +: 8] = expByte(k);
    return f;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model (R9) and drive rule (R10)
  logic prevScl = 1'b1, prevOe = 1'b0;
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (prevScl && mScl) begin
        checks++;
        if (sdaOe !== prevOe) begin
          errors++;
          $display("FAIL R10 actual=%0b expected=%0b", sdaOe, prevOe);
        end
      end
      if (!busy) begin
        checks++;
        if (regOut !== expFlat()) begin
          errors++;
          $display("FAIL R9 actual=%016h expected=%016h", regOut, expFlat());
        end
      end
    end
    prevScl = mScl;
    prevOe  = sdaOe;
  end

  task automatic hw();
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; hw(); mScl = 1'b1; hw(); mSda = 1'b0; hw(); mScl = 1'b0; hw();
  endtask

  task automatic busStop();
    mSda = 1'b0; hw(); mScl = 1'b1; hw(); mSda = 1'b1; hw();
  endtask

  task automatic sendBit(input logic b);
    mSda = b; hw(); mScl = 1'b1; hw(); hw(); mScl = 1'b0; hw();
  endtask

  task automatic recvBit(output logic b);
    mSda = 1'b1; hw(); mScl = 1'b1; hw(); b = sdaBus; hw(); mScl = 1'b0; hw();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(ack);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(nack);
  endtask

  task automatic applyModel(input int off, input logic [7:0] v);
    if (off < 6)       model[off] = v;
    else if (off == 6) model[6] = {v[7:3], 3'b000};
  endtask

  task automatic endTxn();
    busStop();
    hw();
    busy = 1'b0;
  endtask

  task automatic writeByteOp(input string tag, input int off, input logic [7:0] v);
    logic a;
    busy = 1'b1;
    busStart();
    sendByte(8'hD2, a);             check8({tag, " addr ack"}, {7'd0, a}, 8'd0);
    sendByte(8'h80 | 8'(off), a);   check8({tag, " cmd ack"}, {7'd0, a}, 8'd0);
    sendByte(v, a);                 check8({tag, " data ack"}, {7'd0, a}, 8'd0);
    applyModel(off, v);
    endTxn();
  endtask

  task automatic readByteOp(input string tag, input int off);
    logic a;
    logic [7:0] v;
    busy = 1'b1;
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h80 | 8'(off), a);
    busStart();
    sendByte(8'hD3, a);             check8({tag, " read addr ack"}, {7'd0, a}, 8'd0);
    recvByte(1'b1, v);              check8({tag, " read data"}, v, expByte(off));
    endTxn();
  endtask

  task automatic blockWriteOp(input string tag, input int n, input logic [7:0] d [8]);
    logic a;
    busy = 1'b1;
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);             check8({tag, " cmd ack"}, {7'd0, a}, 8'd0);
    sendByte(8'(n), a);             check8({tag, " count ack"}, {7'd0, a}, 8'd0);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], a);            check8({tag, " data ack"}, {7'd0, a}, 8'd0);
      applyModel(i, d[i]);
    end
    endTxn();
  endtask

  task automatic blockReadOp(input string tag, input int n);
    logic a;
    logic [7:0] v;
    busy = 1'b1;
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);
    busStart();
    sendByte(8'hD3, a);
    recvByte(1'b0, v);              check8({tag, " count"}, v, 8'd8);
    for (int i = 0; i < n; i++) begin
      recvByte((i == n - 1), v);    check8({tag, " data"}, v, expByte(i));
    end
    endTxn();
  endtask

  logic [7:0] blk [8];

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    model[0] = 8'hFF; model[1] = 8'hFE; model[2] = 8'hFF;
    model[6] = 8'h18; model[7] = 8'h08;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R6: reset values on the flat output
    checks++;
    if (regOut !== 64'h081D_0000_00FF_FEFF) begin
      errors++;
      $display("FAIL R6 actual=%016h expected=%016h", regOut, 64'h081D_0000_00FF_FEFF);
    end
    busy = 1'b0;
    hw();

    // R6 / R3: every byte read back over the bus
    for (int k = 0; k < 8; k++) readByteOp("R6 R3", k);

    // R2: indexed writes
    writeByteOp("R2", 3, 8'hA5);
    readByteOp("R2", 3);
    writeByteOp("R2", 1, 8'h3C);
    readByteOp("R2", 1);

    // R7: read-only fields and out-of-range offsets
    writeByteOp("R7", 6, 8'h07);
    readByteOp("R7", 6);
    writeByteOp("R7", 7, 8'hFF);
    readByteOp("R7", 7);
    writeByteOp("R7", 10, 8'h55);
    readByteOp("R7", 10);

    // R4: block writes, full and truncated
    blk = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00};
    blockWriteOp("R4", 4, blk);
    blk = '{8'h99, 8'h88, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    blockWriteOp("R4", 2, blk);
    readByteOp("R4", 2);

    // R5: block reads of all bytes and of a prefix
    blockReadOp("R5", 8);
    blockReadOp("R5", 3);

    // R1: foreign address is not acknowledged and has no effect
    begin
      logic a;
      busy = 1'b1;
      busStart();
      sendByte(8'hA0, a); check8("R1 foreign addr nack", {7'd0, a}, 8'd1);
      sendByte(8'h80, a); check8("R1 no cmd ack", {7'd0, a}, 8'd1);
      sendByte(8'h00, a); check8("R1 no data ack", {7'd0, a}, 8'd1);
      endTxn();
      busy = 1'b1;
      busStart();
      sendByte(8'hD0, a); check8("R1 near addr nack", {7'd0, a}, 8'd1);
      endTxn();
      readByteOp("R1", 0);
    end

    // R8: stop during the data byte leaves the register untouched
    begin
      logic a;
      busy = 1'b1;
      busStart();
      sendByte(8'hD2, a);
      sendByte(8'h84, a); check8("R8 cmd ack", {7'd0, a}, 8'd0);
      sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
      endTxn();
      readByteOp("R8", 4);
      writeByteOp("R8", 4, 8'h5A);
      readByteOp("R8", 4);
    end

    // R9 / R7: strap change seen on the output and over the bus
    strap = 3'b010;
    hw();
    readByteOp("R9", 6);

    hw();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule